// File: doc/BRIEF.md
# Montgomery Ladder Modular Exponentiator

This block raises a base to an exponent modulo an odd modulus. Both the base and the result are held in the Montgomery domain with radix 2^WIDTH. It runs the Montgomery powering ladder over two state registers, a low register and a high register. The exponent is read from its most significant bit down. For each bit the block runs one pass of a shared-operand multiplier. That pass forms the product of the two ladder registers and the square of one of them at the same time, and a 2:1 mux picks which register is the shared multiplicand. Each bit therefore costs the same work whether it is 0 or 1, and the run time depends only on the exponent width.

The multiplier works bit-serially. It halves the shared multiplicand modulo n once per cycle and adds each halved value into two accumulators, one per multiplier operand. Each accumulator takes one of its multiplier's bits per cycle, most significant bit first. Every intermediate value stays fully reduced below n, so the block never needs a final subtraction. Before the ladder starts, a load phase doubles 1 modulo n WIDTH times to form the Montgomery one. Converting values into and out of the Montgomery domain is left to the surrounding logic.

Top module: `mpl_exp`

## Requirements
- R1: After reset, `done` is 0 and `result_m` is 0.
- R2: With an odd `modulus` n, where 3 ≤ n < 2^WIDTH, and `base_m` = b·2^WIDTH mod n with b < n, the run that `start` launches ends with `result_m` = (b^e mod n)·2^WIDTH mod n, where e is `exponent` read as an unsigned number.
- R3: An exponent of 0 gives the Montgomery one, 2^WIDTH mod n.
- R4: `done` goes high exactly 1 + WIDTH + EXP_W·(WIDTH+2) cycles after the cycle in which `start` is sampled in idle, for every exponent value and Hamming weight.
- R5: `done` is high for one cycle only, and `result_m` then holds its value until the next accepted `start`.
- R6: A `start` pulse during a run is ignored. The run finishes with the result of the inputs it first captured.
- R7: An exponent of 1 returns `base_m` unchanged.
- R8: Exponent 65537 and the all-ones exponent of EXP_W bits give the R2 result.
- R9: A base of 0 with a nonzero exponent gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a run when the block is idle |
| base_m | input | WIDTH | Base in the Montgomery domain, below the modulus |
| exponent | input | EXP_W | Exponent, unsigned |
| modulus | input | WIDTH | Odd modulus, at least 3 |
| result_m | output | WIDTH | Power in the Montgomery domain |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench uses WIDTH = 16 and EXP_W = 20. At these sizes every expected power, shifted into the Montgomery domain, fits in 64-bit integers inside a bench function. The 20-bit exponent leaves room for 65537, for a full row of ones and for runs of leading zeros. Because the modulus is only 16 bits, a random run can also draw the smallest and largest odd moduli, and the fixed latency of 377 cycles keeps dozens of random runs short.

// File: rtl/mpl_pkg.sv
package mpl_pkg;
  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_LOAD = 2'd1,
    LS_STEP = 2'd2,
    LS_DONE = 2'd3
  } ladder_state_e;
endpackage

// File: rtl/cm_modadd.sv
module cm_modadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  output logic [W-1:0] s
);
  logic         carry;
  logic [W-1:0] low;
  logic         over;

  always_comb begin
    {carry, low} = {1'b0, a} + {1'b0, b};
    over = carry | (low >= n);
    s = over ? (low - n) : low;
  end
endmodule

// File: rtl/cm_halver.sv
module cm_halver #(
  parameter int W = 16
) (
  input  logic [W-1:0] t,
  input  logic [W-1:0] n,
  output logic [W-1:0] h
);
  // (t + n)/2 for odd t, written so that no intermediate needs W+1 bits
  always_comb begin
    h = (t >> 1) + (t[0] ? ((n >> 1) + W'(1)) : '0);
  end
endmodule

// File: rtl/cm_accum.sv
module cm_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         sel,
  input  logic [W-1:0] t,
  input  logic [W-1:0] n,
  output logic [W-1:0] acc
);
  logic [W-1:0] acc_q, acc_d, addend, sum;

  assign addend = sel ? t : '0;

  cm_modadd #(.W(W)) u_add (.a(acc_q), .b(addend), .n(n), .s(sum));

  always_comb begin
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr || en)  acc_q <= acc_d;
  end

  assign acc = acc_q;

  AST_ACC_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (acc_q < n)); // R2
endmodule

// File: rtl/cm_core.sv
module cm_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] p,
  input  logic [W-1:0] mx,
  input  logic [W-1:0] my,
  input  logic [W-1:0] n,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  t_q, t_d, t_half;
  logic [W-1:0]  mx_q, mx_d, my_q, my_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic          load, last;

  assign load = start && !busy_q;
  assign last = (cnt_q == CW'(W - 1));

  cm_halver #(.W(W)) u_half (.t(t_q), .n(n), .h(t_half));

  cm_accum #(.W(W)) u_acc_x (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(busy_q),
    .sel(mx_q[W-1]), .t(t_half), .n(n), .acc(x));

  cm_accum #(.W(W)) u_acc_y (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(busy_q),
    .sel(my_q[W-1]), .t(t_half), .n(n), .acc(y));

  always_comb begin
    t_d    = t_q;
    mx_d   = mx_q;
    my_d   = my_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load) begin
      t_d    = p;
      mx_d   = mx;
      my_d   = my;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      t_d   = t_half;
      mx_d  = {mx_q[W-2:0], 1'b0};
      my_d  = {my_q[W-2:0], 1'b0};
      cnt_d = cnt_q + CW'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q    <= '0;
      mx_q   <= '0;
      my_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load || busy_q) begin
        t_q   <= t_d;
        mx_q  <= mx_d;
        my_q  <= my_d;
        cnt_q <= cnt_d;
      end
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  AST_CORE_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_CORE_T_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (t_half < n)); // R2
endmodule

// File: rtl/mpl_exp.sv
module mpl_exp
  import mpl_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int EXP_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] base_m,
  input  logic [EXP_W-1:0] exponent,
  input  logic [WIDTH-1:0] modulus,
  output logic [WIDTH-1:0] result_m,
  output logic             done
);
  localparam int LCW = $clog2(WIDTH + 1);
  localparam int BCW = $clog2(EXP_W + 1);

  ladder_state_e    state_q, state_d;
  logic [WIDTH-1:0] n_q, n_d, base_q, base_d;
  logic [EXP_W-1:0] e_q, e_d;
  logic [WIDTH-1:0] r0_q, r0_d, r1_q, r1_d, one_q, one_d, one_dbl;
  logic [LCW-1:0]   lcnt_q, lcnt_d;
  logic [BCW-1:0]   bcnt_q, bcnt_d;
  logic             issued_q, issued_d;
  logic             ebit, core_start, core_done;
  logic [WIDTH-1:0] common, other, core_x, core_y;

  cm_modadd #(.W(WIDTH)) u_dbl (.a(one_q), .b(one_q), .n(n_q), .s(one_dbl));

  // exponent bit picks the shared multiplicand
  assign ebit   = e_q[EXP_W-1];
  assign common = ebit ? r1_q : r0_q;
  assign other  = ebit ? r0_q : r1_q;
  assign core_start = (state_q == LS_STEP) && !issued_q;

  cm_core #(.W(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .start(core_start),
    .p(common), .mx(other), .my(common), .n(n_q),
    .x(core_x), .y(core_y), .done(core_done));

  always_comb begin
    state_d  = state_q;
    n_d      = n_q;
    base_d   = base_q;
    e_d      = e_q;
    r0_d     = r0_q;
    r1_d     = r1_q;
    one_d    = one_q;
    lcnt_d   = lcnt_q;
    bcnt_d   = bcnt_q;
    issued_d = issued_q;
    unique case (state_q)
      LS_IDLE: begin
        if (start) begin
          n_d     = modulus;
          base_d  = base_m;
          e_d     = exponent;
          one_d   = WIDTH'(1);
          lcnt_d  = '0;
          bcnt_d  = '0;
          state_d = LS_LOAD;
        end
      end
      LS_LOAD: begin
        one_d  = one_dbl;
        lcnt_d = lcnt_q + LCW'(1);
        if (lcnt_q == LCW'(WIDTH - 1)) begin
          r0_d     = one_dbl;
          r1_d     = base_q;
          issued_d = 1'b0;
          state_d  = LS_STEP;
        end
      end
      LS_STEP: begin
        if (core_start) begin
          issued_d = 1'b1;
        end else if (core_done) begin
          r0_d     = ebit ? core_x : core_y;
          r1_d     = ebit ? core_y : core_x;
          e_d      = {e_q[EXP_W-2:0], 1'b0};
          bcnt_d   = bcnt_q + BCW'(1);
          issued_d = 1'b0;
          if (bcnt_q == BCW'(EXP_W - 1)) state_d = LS_DONE;
        end
      end
      LS_DONE: state_d = LS_IDLE;
      default: state_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LS_IDLE;
      n_q      <= '0;
      base_q   <= '0;
      e_q      <= '0;
      r0_q     <= '0;
      r1_q     <= '0;
      one_q    <= '0;
      lcnt_q   <= '0;
      bcnt_q   <= '0;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      n_q      <= n_d;
      base_q   <= base_d;
      e_q      <= e_d;
      r0_q     <= r0_d;
      r1_q     <= r1_d;
      one_q    <= one_d;
      lcnt_q   <= lcnt_d;
      bcnt_q   <= bcnt_d;
      issued_q <= issued_d;
    end
  end

  assign result_m = r0_q;
  assign done     = (state_q == LS_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != LS_IDLE) |=> ($stable(n_q) && $stable(base_q))); // R6
  AST_LADDER_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_STEP) |-> ((r0_q < n_q) && (r1_q < n_q))); // R2
  AST_LADDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LS_STEP) && !core_done) |=> ($stable(r0_q) && $stable(r1_q))); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LS_IDLE) && !start) |=> $stable(result_m)); // R5
endmodule

// File: tb/mpl_exp_bench.sv
module mpl_exp_bench;
  localparam int WIDTH = 16;
  localparam int EXP_W = 20;
  localparam int LAT   = 1 + WIDTH + EXP_W * (WIDTH + 2);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] base_m = '0;
  logic [EXP_W-1:0] exponent = '0;
  logic [WIDTH-1:0] modulus = '0;
  logic [WIDTH-1:0] result_m;
  logic             done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mpl_exp #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_mpl_exp (
    .clk(clk), .rst_n(rst_n), .start(start), .base_m(base_m),
    .exponent(exponent), .modulus(modulus), .result_m(result_m), .done(done));

  function automatic longint powmod(longint b, longint e, longint n);
    longint acc = 1 % n;
    longint sq  = b % n;
    for (int i = 0; i < 64; i++) begin
      if (e[i]) acc = (acc * sq) % n;
      sq = (sq * sq) % n;
    end
    return acc;
  endfunction

  function automatic longint to_mont(longint v, longint n);
    return (v << WIDTH) % n;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one exponentiation; returns result and cycles until done
  task automatic run_op(input longint b, input longint e, input longint n,
                        output longint res, output int lat);
    @(negedge clk);
    base_m   = WIDTH'(to_mont(b, n));
    exponent = EXP_W'(e);
    modulus  = WIDTH'(n);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    res = longint'(result_m);
  endtask

  task automatic do_case(input longint b, input longint e, input longint n, input string req);
    longint res, held;
    int lat;
    run_op(b, e, n, res, lat);
    check(res == to_mont(powmod(b, e, n), n), req, res, to_mont(powmod(b, e, n), n));
    check(lat == LAT, "R4 latency", lat, LAT);
    @(negedge clk);
    held = longint'(result_m);
    check(!done, "R5 done single cycle", longint'(done), 0);
    repeat (5) @(negedge clk);
    check(longint'(result_m) == res && held == res, "R5 result held", longint'(result_m), res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint n, b, e, res;
    int lat;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    check(!done, "R1 done after reset", longint'(done), 0);
    check(result_m == '0, "R1 result after reset", longint'(result_m), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_case(1234, 0, 40961, "R3 zero exponent");
    do_case(4321, 1, 40961, "R7 exponent one");
    do_case(777, 65537, 65521, "R8 exponent 65537");
    do_case(31415, (1 << EXP_W) - 1, 65535, "R8 all-ones exponent");
    do_case(0, 99, 60001, "R9 zero base");
    do_case(2, 12345, 3, "R2 smallest modulus");
    do_case(65534, 3, 65535, "R2 largest base");
    do_case(5, 1 << (EXP_W - 1), 52429, "R2 single top bit");

    // R6: a second start during a run must not disturb it
    n = 50021; b = 9876; e = 654321;
    @(negedge clk);
    base_m = WIDTH'(to_mont(b, n)); exponent = EXP_W'(e); modulus = WIDTH'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    base_m = WIDTH'(17); exponent = EXP_W'(3); modulus = WIDTH'(101);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    res = longint'(result_m);
    check(res == to_mont(powmod(b, e, n), n), "R6 start ignored while busy", res,
          to_mont(powmod(b, e, n), n));
    repeat (3) @(negedge clk);

    for (int k = 0; k < 30; k++) begin
      n = longint'($urandom % 32767) * 2 + 3;
      b = longint'($urandom) % n;
      e = longint'($urandom % (1 << EXP_W));
      do_case(b, e, n, "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule